// File: doc/BRIEF.md
# Video Memory Slot Scheduler

This block decides who owns a video controller's memory port in each pixel-clock slot of a scanline. It divides the master clock by a fixed ratio to form a pixel enable. At every enable edge it looks at the current horizontal position, an active-scan flag and the non-empty status of a pending-write queue, and then issues one grant for the whole next slot. A slot goes to the renderer's fixed fetches, to an external CPU or DMA write popped from the queue, or to a DRAM row refresh. If none of these applies, the slot is idle.

During active scan, external writes get only sparse slots at fixed positions. The rest of the line feeds the renderer. Renderer slots carry a fetch tag: a section index and a subslot within that section. The tag is taken from a position that runs a fixed number of pixels ahead of the raster, so data is fetched before it is drawn. The last section is reserved for sprite fetches. A refresh cycle takes every fourth external slot position on every line, in active scan and blanking alike. Each refresh steps a row address that wraps. Outside active scan, every slot that is not a refresh goes to the queue whenever the queue holds an entry.

Top module: `vss_slot_sched`

## Requirements
- R1: The pixel enable fires once every 8 master clocks. `grant`, `fetch_sec` and `fetch_sub` change only on the master edge where the enable is high, and hold for the 8 clocks of the slot.
- R2: While reset is held, the outputs are: `grant` = 2'b11 (idle), `fifo_pop` = 0, `refresh_row` = 0, `fetch_sec` = 3'd7, `fetch_sub` = 0.
- R3: When `active` = 1 and the slot is not a refresh slot, two cases apply. If `hpos` mod 16 == 0, the grant is 2'b01 (external), whatever the queue status. Otherwise the grant is 2'b00 (render).
- R4: When `hpos` mod 64 == 48, the grant is 2'b10 (refresh). This holds whatever the values of `active` and `fifo_nempty`, so during active scan writes are 32 pixels apart around a refresh.
- R5: When `active` = 0 and the slot is not a refresh slot, the grant is 2'b01 if `fifo_nempty` = 1 and 2'b11 (idle) otherwise.
- R6: `fifo_pop` is high for exactly one master clock, the first clock of a slot. This happens only when that slot's grant is 2'b01 and `fifo_nempty` was 1 at the deciding edge. An external slot with an empty queue produces no pop.
- R7: `refresh_row` addresses row 0 at the first refresh after reset. Each later refresh slot addresses the next row, 255 wraps to 0, and the value holds between refreshes.
- R8: In a render slot, let f = `hpos` + 8. If f < 384, then `fetch_sec` = f div 64 and `fetch_sub` = (f mod 64) div 16. Section 5 holds the sprite fetches and sections 0 to 4 the background planes. In every other case `fetch_sec` = 7 and `fetch_sub` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hpos | input | 9 | Horizontal pixel position of the slot being decided |
| active | input | 1 | High during active scan, low in border and blanking |
| fifo_nempty | input | 1 | Pending-write queue holds at least one entry |
| grant | output | 2 | Slot owner: 00 render, 01 external, 10 refresh, 11 idle |
| refresh_row | output | 8 | DRAM row refreshed in the current refresh slot |
| fifo_pop | output | 1 | One-clock pop strobe to the write queue |
| fetch_sec | output | 3 | Fetch section of a render slot, 7 when none |
| fetch_sub | output | 2 | Fetch subslot within the section |

## Verification
The hardest case to reach is the wrap of the refresh row from 255 to 0. On a real line this needs 256 refresh slots, which is more than sixteen thousand pixels. Because `hpos` is an input, the stimulus drives the refresh position in consecutive slots and reaches the wrap in a few hundred slots, while `active` and the queue status change underneath. Random positions come next, and they exercise every place where a refresh slot lands on an external slot, including active external slots with an empty queue, where no pop is allowed.

// File: rtl/vss_pkg.sv
package vss_pkg;

   typedef enum logic [1:0] {
      GNT_RENDER  = 2'b00,
      GNT_EXT     = 2'b01,
      GNT_REFRESH = 2'b10,
      GNT_IDLE    = 2'b11
   } gnt_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/vss_pixdiv.sv
module vss_pixdiv #(
   parameter int DIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   output logic pix_en
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   logic [CW-1:0] cnt_q;

   generate
      if (vss_pkg::is_pow2(DIV)) begin : g_pow2
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_q + ONE;
         end
         assign pix_en = &cnt_q;
      end else begin : g_mod
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else                    cnt_q <= cnt_q + ONE;
         end
         assign pix_en = (cnt_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/vss_slot_decode.sv
module vss_slot_decode
   import vss_pkg::*;
#(
   parameter int HPOS_W     = 9,
   parameter int EXT_PERIOD = 16,
   parameter int EXT_OFS    = 0,
   parameter int REF_EVERY  = 4,
   parameter int REF_SEL    = 3,
   parameter int SEC_PIX    = 64,
   parameter int SUB_PIX    = 16,
   parameter int SECTIONS   = 6,
   parameter int LEAD       = 8,
   parameter int SEC_W      = 3,
   parameter int SUB_W      = 2
) (
   input  logic [HPOS_W-1:0] hpos,
   input  logic              active,
   input  logic              fifo_nempty,
   output gnt_e              gnt_nxt,
   output logic              pop_nxt,
   output logic [SEC_W-1:0]  sec_nxt,
   output logic [SUB_W-1:0]  sub_nxt
);
   localparam int EXT_SH     = $clog2(EXT_PERIOD);
   localparam int REF_PERIOD = EXT_PERIOD * REF_EVERY;
   localparam int REF_SH     = $clog2(REF_PERIOD);
   localparam int REF_POS    = REF_SEL * EXT_PERIOD + EXT_OFS;
   localparam int SEC_SH     = $clog2(SEC_PIX);
   localparam int SUB_SH     = $clog2(SUB_PIX);
   localparam int SPAN       = SEC_PIX * SECTIONS;

   localparam logic [EXT_SH-1:0] EXT_OFS_V = EXT_OFS[EXT_SH-1:0];
   localparam logic [REF_SH-1:0] REF_POS_V = REF_POS[REF_SH-1:0];
   localparam logic [HPOS_W:0]   LEAD_V    = LEAD[HPOS_W:0];
   localparam logic [HPOS_W:0]   SPAN_V    = SPAN[HPOS_W:0];

   logic              ext_hit;
   logic              ref_hit;
   logic [HPOS_W:0]   fpos;
   logic              in_span;
   logic [HPOS_W-SEC_SH:0] sec_all;

   assign ext_hit = (hpos[EXT_SH-1:0] == EXT_OFS_V);
   assign ref_hit = (hpos[REF_SH-1:0] == REF_POS_V);
   assign fpos    = {1'b0, hpos} + LEAD_V;
   assign in_span = (fpos < SPAN_V);
   assign sec_all = fpos[HPOS_W:SEC_SH];

   always_comb begin
      if (ref_hit)          gnt_nxt = GNT_REFRESH;
      else if (active)      gnt_nxt = ext_hit ? GNT_EXT : GNT_RENDER;
      else if (fifo_nempty) gnt_nxt = GNT_EXT;
      else                  gnt_nxt = GNT_IDLE;
   end

   assign pop_nxt = (gnt_nxt == GNT_EXT) && fifo_nempty;

   always_comb begin
      if ((gnt_nxt == GNT_RENDER) && in_span) begin
         sec_nxt = sec_all[SEC_W-1:0];
         sub_nxt = fpos[SEC_SH-1:SUB_SH];
      end else begin
         sec_nxt = '1;
         sub_nxt = '0;
      end
   end

endmodule

// File: rtl/vss_refresh_row.sv
module vss_refresh_row #(
   parameter int ROW_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [ROW_W-1:0] row
);
   localparam logic [ROW_W-1:0] ONE = {{(ROW_W-1){1'b0}}, 1'b1};

   logic [ROW_W-1:0] next_q;
   logic [ROW_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         next_q <= '0;
         addr_q <= '0;
      end else if (step) begin
         addr_q <= next_q;
         next_q <= next_q + ONE;
      end
   end

   assign row = addr_q;

endmodule

// File: rtl/vss_slot_sched.sv
module vss_slot_sched
   import vss_pkg::*;
#(
   parameter int DIV        = 8,
   parameter int HPOS_W     = 9,
   parameter int EXT_PERIOD = 16,
   parameter int EXT_OFS    = 0,
   parameter int REF_EVERY  = 4,
   parameter int REF_SEL    = 3,
   parameter int ROW_W      = 8,
   parameter int SEC_PIX    = 64,
   parameter int SUB_PIX    = 16,
   parameter int SECTIONS   = 6,
   parameter int LEAD       = 8,
   localparam int SEC_W     = $clog2(SECTIONS + 1),
   localparam int SUB_W     = $clog2(SEC_PIX / SUB_PIX)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HPOS_W-1:0] hpos,
   input  logic              active,
   input  logic              fifo_nempty,
   output logic [1:0]        grant,
   output logic [ROW_W-1:0]  refresh_row,
   output logic              fifo_pop,
   output logic [SEC_W-1:0]  fetch_sec,
   output logic [SUB_W-1:0]  fetch_sub
);
   localparam int REF_SH = $clog2(EXT_PERIOD * REF_EVERY);
   localparam int SEC_SH = $clog2(SEC_PIX);

   if (DIV < 2) begin : g_bad_div
      $error("DIV must be at least 2");
   end
   if (!is_pow2(EXT_PERIOD) || !is_pow2(REF_EVERY) || (REF_EVERY < 2)) begin : g_bad_ext
      $error("EXT_PERIOD and REF_EVERY must be powers of two, REF_EVERY >= 2");
   end
   if ((EXT_OFS >= EXT_PERIOD) || (REF_SEL >= REF_EVERY)) begin : g_bad_ofs
      $error("EXT_OFS or REF_SEL out of range");
   end
   if (!is_pow2(SEC_PIX) || !is_pow2(SUB_PIX) || (SEC_PIX < 2 * SUB_PIX)) begin : g_bad_sec
      $error("SEC_PIX and SUB_PIX must be powers of two with at least two subslots");
   end
   if ((HPOS_W < REF_SH) || (HPOS_W - SEC_SH + 1 < SEC_W)) begin : g_bad_hpos
      $error("HPOS_W too narrow for the slot pattern");
   end
   if ((SEC_PIX * SECTIONS >= 2 ** (HPOS_W + 1)) || (LEAD >= 2 ** HPOS_W)) begin : g_bad_span
      $error("fetch span or lead does not fit the position width");
   end

   logic             pix_en;
   gnt_e             gnt_nxt;
   logic             pop_nxt;
   logic [SEC_W-1:0] sec_nxt;
   logic [SUB_W-1:0] sub_nxt;
   gnt_e             gnt_q;
   logic             pop_q;
   logic [SEC_W-1:0] sec_q;
   logic [SUB_W-1:0] sub_q;

   vss_pixdiv #(.DIV(DIV)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .pix_en (pix_en)
   );

   vss_slot_decode #(
      .HPOS_W     (HPOS_W),
      .EXT_PERIOD (EXT_PERIOD),
      .EXT_OFS    (EXT_OFS),
      .REF_EVERY  (REF_EVERY),
      .REF_SEL    (REF_SEL),
      .SEC_PIX    (SEC_PIX),
      .SUB_PIX    (SUB_PIX),
      .SECTIONS   (SECTIONS),
      .LEAD       (LEAD),
      .SEC_W      (SEC_W),
      .SUB_W      (SUB_W)
   ) u_dec (
      .hpos        (hpos),
      .active      (active),
      .fifo_nempty (fifo_nempty),
      .gnt_nxt     (gnt_nxt),
      .pop_nxt     (pop_nxt),
      .sec_nxt     (sec_nxt),
      .sub_nxt     (sub_nxt)
   );

   vss_refresh_row #(.ROW_W(ROW_W)) u_row (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (pix_en && (gnt_nxt == GNT_REFRESH)),
      .row   (refresh_row)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt_q <= GNT_IDLE;
         sec_q <= '1;
         sub_q <= '0;
         pop_q <= 1'b0;
      end else begin
         pop_q <= pix_en && pop_nxt;
         if (pix_en) begin
            gnt_q <= gnt_nxt;
            sec_q <= sec_nxt;
            sub_q <= sub_nxt;
         end
      end
   end

   assign grant     = gnt_q;
   assign fifo_pop  = pop_q;
   assign fetch_sec = sec_q;
   assign fetch_sub = sub_q;

endmodule

// File: rtl/vss_slot_sched_chk.sv
module vss_slot_sched_chk #(
   parameter int ROW_W = 8,
   parameter int SEC_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pix_en,
   input logic [1:0]       grant,
   input logic             fifo_pop,
   input logic [ROW_W-1:0] refresh_row,
   input logic [SEC_W-1:0] fetch_sec
);
   localparam logic [ROW_W-1:0] ONE = {{(ROW_W-1){1'b0}}, 1'b1};

   logic [ROW_W-1:0] prev_row;
   logic [ROW_W-1:0] row_step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_row <= '0;
      else        prev_row <= refresh_row;
   end
   assign row_step = refresh_row - prev_row;

   // R1
   grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(pix_en) |-> $stable(grant));

   // R6
   pop_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> (grant == 2'b01));

   // R6
   pop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |=> !fifo_pop);

   // R7
   row_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(refresh_row) |-> (grant == 2'b10));

   // R7
   row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(refresh_row) |-> (row_step == ONE));

   // R8
   sec_render_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_sec != '1) |-> (grant == 2'b00));

endmodule

bind vss_slot_sched vss_slot_sched_chk #(.ROW_W(ROW_W), .SEC_W(SEC_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pix_en      (pix_en),
   .grant       (grant),
   .fifo_pop    (fifo_pop),
   .refresh_row (refresh_row),
   .fetch_sec   (fetch_sec)
);

// File: tb/sim_vss_slot_sched.sv
module sim_vss_slot_sched;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [8:0] hpos = '0;
   logic       active = 1'b0;
   logic       fifo_ne = 1'b0;
   logic [1:0] grant;
   logic [7:0] refresh_row;
   logic       fifo_pop;
   logic [2:0] fetch_sec;
   logic [1:0] fetch_sub;

   int checks = 0;
   int failures = 0;
   int ref_cnt = 0;
   logic [1:0] prev_g = 2'b11;
   logic [7:0] prev_row = '0;
   bit done = 0;

   always #10 clk = ~clk;

   vss_slot_sched u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .hpos        (hpos),
      .active      (active),
      .fifo_nempty (fifo_ne),
      .grant       (grant),
      .refresh_row (refresh_row),
      .fifo_pop    (fifo_pop),
      .fetch_sec   (fetch_sec),
      .fetch_sub   (fetch_sub)
   );

   function automatic logic [1:0] exp_grant(input int h, input bit a, input bit ne);
      if (h % 64 == 48) return 2'b10;
      if (a)            return (h % 16 == 0) ? 2'b01 : 2'b00;
      return ne ? 2'b01 : 2'b11;
   endfunction

   function automatic logic [2:0] exp_sec(input int h, input logic [1:0] g);
      int f = h + 8;
      if (g != 2'b00 || f >= 384) return 3'd7;
      return 3'(f / 64);
   endfunction

   function automatic logic [1:0] exp_sub(input int h, input logic [1:0] g);
      int f = h + 8;
      if (g != 2'b00 || f >= 384) return 2'd0;
      return 2'((f % 64) / 16);
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic run_slot(input int h, input bit a, input bit ne);
      logic [1:0] eg;
      logic [7:0] er;
      hpos = 9'(h); active = a; fifo_ne = ne;
      @(posedge clk); @(negedge clk);
      // R1: grant held through the slot, R6: pop lasts one clock
      check(grant == prev_g, "R1", "grant mid-slot", grant, prev_g);
      check(fifo_pop == 1'b0, "R6", "pop mid-slot", fifo_pop, 0);
      repeat (7) @(posedge clk);
      @(negedge clk);
      eg = exp_grant(h, a, ne);
      if (eg == 2'b10) begin
         er = 8'(ref_cnt);
         ref_cnt++;
      end else begin
         er = prev_row;
      end
      check(grant == eg, (eg == 2'b10) ? "R4" : (a ? "R3" : "R5"), "grant", grant, eg);
      check(fifo_pop == (eg == 2'b01 && ne), "R6", "pop", fifo_pop, int'(eg == 2'b01 && ne));
      check(refresh_row == er, "R7", "row", refresh_row, er);
      check(fetch_sec == exp_sec(h, eg), "R8", "fetch_sec", fetch_sec, exp_sec(h, eg));
      check(fetch_sub == exp_sub(h, eg), "R8", "fetch_sub", fetch_sub, exp_sub(h, eg));
      prev_g = eg;
      prev_row = er;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL R1 watchdog expired actual=%0d expected=%0d", checks, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R2 reset state
      check(grant == 2'b11, "R2", "reset grant", grant, 3);
      check(fifo_pop == 1'b0, "R2", "reset pop", fifo_pop, 0);
      check(refresh_row == 8'd0, "R2", "reset row", refresh_row, 0);
      check(fetch_sec == 3'd7, "R2", "reset sec", fetch_sec, 7);
      check(fetch_sub == 2'd0, "R2", "reset sub", fetch_sub, 0);
      rst_n = 1'b1;

      // directed: full line sweep, queue status toggling every 32 pixels
      for (int h = 0; h < 448; h++) run_slot(h, h < 384, h[5]);
      // directed: active external slots with an empty queue (R6 lost slot)
      for (int k = 0; k < 8; k++) run_slot(k * 64 + 16, 1'b1, 1'b0);
      // directed: blanking with empty then full queue (R5)
      for (int k = 0; k < 32; k++) run_slot(384 + k, 1'b0, k[4]);

      // random positions and flags
      for (int n = 0; n < 600; n++) begin
         int h = int'($urandom % 448);
         bit a = ($urandom % 4) != 0;
         bit ne = ($urandom % 2) != 0;
         run_slot(h, a, ne);
      end

      // R7 wrap: hammer the refresh position past 256 refreshes
      while (ref_cnt < 262) begin
         bit a = ($urandom % 2) != 0;
         bit ne = ($urandom % 2) != 0;
         run_slot(48 + 64 * int'($urandom % 7), a, ne);
      end
      // R7 row held on a following non-refresh slot
      run_slot(17, 1'b1, 1'b1);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule